// File: doc/BRIEF.md
# Event-Selectable Performance Counter Bank

This block is a bank of programmable 64-bit hardware event counters for a small processor core. Each counter slot holds a numeric event-select code. In every clock cycle a slot adds one to its count when two things are true: the event it has selected pulses on the event input vector, and its own enable bit in a shared 32-bit control word is set. Slot i is gated by control bit (3 + i), so the default 29 slots line up with architectural counter numbers 3 through 31.

Software reaches the bank through a single-cycle write port and a combinational read port. Both ports address the control word, a slot's event selector or a slot's count. A write to a count in the same cycle as an increment stores the written value. A per-slot "changed" flag records which counters were incremented during the current instruction. The core clears all of these flags with an instruction-boundary pulse. The core's pipeline produces the event pulses; this block only counts them.

Top module: `perf_bank`

## Requirements
- R1: After reset every count, every selector, the control word and every changed flag read as zero.
- R2: Slot i adds exactly one to its 64-bit count in a cycle when its selector s lies in 1..56, evt_i[s] is 1 and control bit (3 + i) is 1. The new value is visible on the next cycle.
- R3: While control bit (3 + i) is 0, slot i keeps its count even when its selected event pulses.
- R4: Selector code 0 means no event. A slot with selector 0 never counts, and evt_i[0] never causes counting.
- R5: A selector write stores codes 1..56 as written. Any written value above 56 stores 0, and a read of that selector then returns 0.
- R6: Any number of slots may select the same code. All enabled slots that do so increment in the same cycle.
- R7: A count write to slot i stores wr_data_i unchanged, even if slot i would have incremented in that cycle.
- R8: mod_o[i] becomes 1 in the cycle after slot i increments. It stays 1 until a cycle with instr_end_i = 1, after which all flags are 0. instr_end_i also takes priority over an increment in the same cycle. Writes never set a flag.
- R9: An increment of a count holding all ones wraps it to zero.
- R10: Register kinds are selected by wr_kind_i and rd_kind_i: 0 is the control word (low 32 bits of data), 1 is a selector, 2 is a count, and 3 is unused. A write of kind 3, or of kind 1 or 2 with index 29 or above, changes nothing. Reads of these locations return 0.
- R11: rd_data_o shows the addressed register's current value in the same cycle, with no register stage. Reads of the control word and of selectors are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 57 | Per-cycle event pulses; bit n is event code n |
| instr_end_i | input | 1 | Instruction boundary; clears changed flags |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 2 | Write target kind (0 control, 1 selector, 2 count) |
| wr_idx_i | input | 5 | Slot index for selector/count writes |
| wr_data_i | input | 64 | Write data |
| rd_kind_i | input | 2 | Read target kind |
| rd_idx_i | input | 5 | Slot index for reads |
| rd_data_o | output | 64 | Read data |
| mod_o | output | 29 | Per-slot changed-this-instruction flags |

## Verification
The bench checks that a count holding all ones wraps to zero. A design with a short carry chain would leave upper bits set instead. It writes selector codes 56, 57 and 63, which separates the correct clamp to zero from a design that masks bits and starts counting some unrelated event. It drives evt_i[0] high against selector 0, collides a count write with an increment, and pulses the instruction boundary in the same cycle as an increment; a design with the wrong priority in either case leaves a stale flag or an off-by-one count. Random traffic then mixes shared selectors, toggled enable bits and out-of-range indices, and the bench compares its own model against the changed flags and one read-back every cycle.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int EVT_N     = 57;
  localparam int EVT_MAX   = 56;
  localparam int SEL_W     = 6;
  localparam int CTR_W     = 64;
  localparam int CTRL_W    = 32;
  localparam int SLOT_BASE = 3;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_SEL  = 2'd1,
    REG_CNT  = 2'd2,
    REG_NONE = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/perf_evt_pick.sv
module perf_evt_pick #(
  parameter int EVT_N   = perf_pkg::EVT_N,
  parameter int EVT_MAX = perf_pkg::EVT_MAX,
  parameter int SEL_W   = perf_pkg::SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_N-1:0] evt_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             hit_o
);
  localparam int PAD_N = 1 << SEL_W;

  logic [PAD_N-1:0] evt_pad;

  // code 0 is "no event": mask bit 0, pad unused codes with zero
  assign evt_pad = PAD_N'(evt_i & ~EVT_N'(1));
  assign hit_o   = (sel_i <= SEL_W'(EVT_MAX)) & evt_pad[sel_i];

  // R4
  no_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0) |-> !hit_o);
endmodule

// File: rtl/perf_ctr_slot.sv
module perf_ctr_slot #(
  parameter int EVT_N   = perf_pkg::EVT_N,
  parameter int EVT_MAX = perf_pkg::EVT_MAX,
  parameter int SEL_W   = perf_pkg::SEL_W,
  parameter int CTR_W   = perf_pkg::CTR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_N-1:0] evt_i,
  input  logic             en_i,
  input  logic             sel_we_i,
  input  logic             cnt_we_i,
  input  logic [CTR_W-1:0] wdata_i,
  input  logic             clr_mod_i,
  output logic [CTR_W-1:0] cnt_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             mod_o
);
  logic [CTR_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             mod_q;
  logic             hit, inc;

  perf_evt_pick #(
    .EVT_N  (EVT_N),
    .EVT_MAX(EVT_MAX),
    .SEL_W  (SEL_W)
  ) u_pick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt_i),
    .sel_i (sel_q),
    .hit_o (hit)
  );

  assign inc   = en_i & hit & ~cnt_we_i;
  // out-of-range codes collapse to "no event"
  assign sel_d = (wdata_i > CTR_W'(EVT_MAX)) ? '0 : wdata_i[SEL_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= '0;
      mod_q <= 1'b0;
    end else begin
      if (cnt_we_i)  cnt_q <= wdata_i;
      else if (inc)  cnt_q <= cnt_q + 1'b1;
      if (sel_we_i)  sel_q <= sel_d;
      if (clr_mod_i) mod_q <= 1'b0;
      else if (inc)  mod_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign sel_o = sel_q;
  assign mod_o = mod_q;

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_we_i) |=> $stable(cnt_q));
  // R2
  inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && hit && !cnt_we_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R7
  wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> (cnt_q == $past(wdata_i)));
  // R5
  sel_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q <= SEL_W'(EVT_MAX));
  // R8
  mod_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_mod_i |=> !mod_q);
endmodule

// File: rtl/perf_rd_mux.sv
module perf_rd_mux #(
  parameter int NUM_CTR = 29,
  parameter int IDX_W   = 5,
  parameter int SEL_W   = perf_pkg::SEL_W,
  parameter int CTR_W   = perf_pkg::CTR_W,
  parameter int CTRL_W  = perf_pkg::CTRL_W
) (
  input  logic [1:0]                     kind_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic [CTRL_W-1:0]              ctrl_i,
  input  logic [NUM_CTR-1:0][SEL_W-1:0]  sel_i,
  input  logic [NUM_CTR-1:0][CTR_W-1:0]  cnt_i,
  output logic [CTR_W-1:0]               data_o
);
  import perf_pkg::*;

  logic idx_ok;
  assign idx_ok = (32'(idx_i) < NUM_CTR);

  always_comb begin
    data_o = '0;
    case (reg_kind_e'(kind_i))
      REG_CTRL: data_o = CTR_W'(ctrl_i);
      REG_SEL:  if (idx_ok) data_o = CTR_W'(sel_i[idx_i]);
      REG_CNT:  if (idx_ok) data_o = cnt_i[idx_i];
      default:  data_o = '0;
    endcase
  end
endmodule

// File: rtl/perf_bank.sv
module perf_bank #(
  parameter int NUM_CTR   = 29,
  parameter int EVT_N     = perf_pkg::EVT_N,
  parameter int EVT_MAX   = perf_pkg::EVT_MAX,
  parameter int SEL_W     = perf_pkg::SEL_W,
  parameter int CTR_W     = perf_pkg::CTR_W,
  parameter int CTRL_W    = perf_pkg::CTRL_W,
  parameter int SLOT_BASE = perf_pkg::SLOT_BASE,
  localparam int IDX_W    = $clog2(NUM_CTR)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [EVT_N-1:0]   evt_i,
  input  logic               instr_end_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_kind_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [CTR_W-1:0]   wr_data_i,
  input  logic [1:0]         rd_kind_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [CTR_W-1:0]   rd_data_o,
  output logic [NUM_CTR-1:0] mod_o
);
  import perf_pkg::*;

  logic [CTRL_W-1:0]              ctrl_q;
  logic [NUM_CTR-1:0][SEL_W-1:0]  sel_all;
  logic [NUM_CTR-1:0][CTR_W-1:0]  cnt_all;
  logic                           ctrl_we;

  assign ctrl_we = wr_en_i & (reg_kind_e'(wr_kind_i) == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= wr_data_i[CTRL_W-1:0];
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
    logic idx_hit;
    assign idx_hit = wr_en_i & (wr_idx_i == IDX_W'(i));

    perf_ctr_slot #(
      .EVT_N  (EVT_N),
      .EVT_MAX(EVT_MAX),
      .SEL_W  (SEL_W),
      .CTR_W  (CTR_W)
    ) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_i),
      .en_i     (ctrl_q[SLOT_BASE+i]),
      .sel_we_i (idx_hit & (reg_kind_e'(wr_kind_i) == REG_SEL)),
      .cnt_we_i (idx_hit & (reg_kind_e'(wr_kind_i) == REG_CNT)),
      .wdata_i  (wr_data_i),
      .clr_mod_i(instr_end_i),
      .cnt_o    (cnt_all[i]),
      .sel_o    (sel_all[i]),
      .mod_o    (mod_o[i])
    );
  end

  perf_rd_mux #(
    .NUM_CTR(NUM_CTR),
    .IDX_W  (IDX_W),
    .SEL_W  (SEL_W),
    .CTR_W  (CTR_W),
    .CTRL_W (CTRL_W)
  ) u_rd (
    .kind_i(rd_kind_i),
    .idx_i (rd_idx_i),
    .ctrl_i(ctrl_q),
    .sel_i (sel_all),
    .cnt_i (cnt_all),
    .data_o(rd_data_o)
  );

  // R10
  ctrl_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we |=> $stable(ctrl_q));
  // R8
  mod_clear_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_end_i |=> (mod_o == '0));
endmodule

// File: tb/sim_perf_bank.sv
module sim_perf_bank;
  localparam int CLK_P = 10;
  localparam int N     = 29;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [56:0] evt = '0;
  logic        iend = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  wk = '0, rk = '0;
  logic [4:0]  wi = '0, ri = '0;
  logic [63:0] wd = '0;
  logic [63:0] rd;
  logic [N-1:0] mod;

  int total = 0, bad = 0;
  bit done = 0;

  logic [63:0] m_cnt [N];
  logic [5:0]  m_sel [N];
  logic [31:0] m_ctrl;
  logic [N-1:0] m_mod;

  always #(CLK_P/2) clk = ~clk;

  perf_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .instr_end_i(iend),
    .wr_en_i(we), .wr_kind_i(wk), .wr_idx_i(wi), .wr_data_i(wd),
    .rd_kind_i(rk), .rd_idx_i(ri), .rd_data_o(rd), .mod_o(mod)
  );

  function automatic logic [63:0] model_rd(input logic [1:0] k, input logic [4:0] i);
    if (k == 2'd0) return {32'd0, m_ctrl};
    if (k == 2'd1 && i < N) return {58'd0, m_sel[i]};
    if (k == 2'd2 && i < N) return m_cnt[i];
    return 64'd0;
  endfunction

  // model: one clock edge with the inputs currently driven
  task automatic model_edge();
    for (int i = 0; i < N; i++) begin
      bit wc = we && wk == 2'd2 && wi == i;
      bit ws = we && wk == 2'd1 && wi == i;
      bit inc = m_sel[i] != 0 && evt[m_sel[i]] && m_ctrl[3+i] && !wc;
      if (wc) m_cnt[i] = wd;
      else if (inc) m_cnt[i] = m_cnt[i] + 64'd1;
      if (ws) m_sel[i] = (wd > 64'd56) ? 6'd0 : wd[5:0];
      if (iend) m_mod[i] = 1'b0;
      else if (inc) m_mod[i] = 1'b1;
    end
    if (we && wk == 2'd0) m_ctrl = wd[31:0];
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] k, input logic [4:0] i);
    rk = k; ri = i;
    #1;
    chk(tag, rd, model_rd(k, i));
  endtask

  // inputs are set after a negedge; this advances one edge and returns at the next negedge
  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    we = 1'b0; iend = 1'b0; evt = '0;
  endtask

  task automatic wr(input logic [1:0] k, input logic [4:0] i, input logic [63:0] d);
    we = 1'b1; wk = k; wi = i; wd = d;
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_cnt[i] = '0; m_sel[i] = '0; end
    m_ctrl = '0; m_mod = '0;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mod", {35'd0, mod}, 64'd0);
    rd_chk("R1 ctrl", 2'd0, 5'd0);
    rd_chk("R1 sel", 2'd1, 5'd7);
    rd_chk("R1 cnt", 2'd2, 5'd28);
    rst_n = 1'b1;
    @(negedge clk);

    // R12-style control read-back, R11 same-cycle read
    wr(2'd0, 5'd0, 64'hffff_ffff_ffff_fff8);
    rd_chk("R10 ctrl low 32 bits", 2'd0, 5'd0);

    // R5 selector clamp
    wr(2'd1, 5'd0, 64'd56);
    rd_chk("R5 sel 56 kept", 2'd1, 5'd0);
    chk("R5 sel 56 value", rd, 64'd56);
    wr(2'd1, 5'd1, 64'd57);
    rd_chk("R5 sel 57 -> 0", 2'd1, 5'd1);
    chk("R5 sel 57 value", rd, 64'd0);
    wr(2'd1, 5'd2, 64'd63);
    rd_chk("R5 sel 63 -> 0", 2'd1, 5'd2);
    wr(2'd1, 5'd3, 64'h1_0000_0004);
    rd_chk("R5 sel wide -> 0", 2'd1, 5'd3);

    // R4 selector 0 with all events firing, including bit 0
    evt = '1; cyc();
    rd_chk("R4 sel0 no count", 2'd2, 5'd1);
    chk("R4 sel0 zero", rd, 64'd0);
    rd_chk("R2 sel56 counts", 2'd2, 5'd0);
    chk("R2 sel56 one", rd, 64'd1);
    chk("R8 mod set", {35'd0, mod}, {35'd0, m_mod});

    // R9 wrap
    wr(2'd2, 5'd0, '1);
    evt[56] = 1'b1; cyc();
    rd_chk("R9 wrap to zero", 2'd2, 5'd0);
    chk("R9 wrap value", rd, 64'd0);

    // R7 write during increment; R8 instr_end beats increment
    evt[56] = 1'b1; iend = 1'b1; we = 1'b1; wk = 2'd2; wi = 5'd0; wd = 64'h1234;
    cyc();
    rd_chk("R7 write wins", 2'd2, 5'd0);
    chk("R7 value", rd, 64'h1234);
    chk("R8 cleared", {35'd0, mod}, 64'd0);
    evt[56] = 1'b1; iend = 1'b1; cyc();
    chk("R8 end beats inc", {35'd0, mod}, 64'd0);
    rd_chk("R8 count still incremented", 2'd2, 5'd0);

    // R6 shared event; R3 enable off for slot 5
    for (int i = 4; i < 8; i++) wr(2'd1, 5'(i), 64'd4);
    wr(2'd0, 5'd0, 64'hffff_ffff & ~(64'd1 << 8));
    evt[4] = 1'b1; cyc();
    for (int i = 4; i < 8; i++) rd_chk("R6 shared event", 2'd2, 5'(i));
    rd_chk("R3 disabled holds", 2'd2, 5'd5);
    chk("R3 disabled value", rd, 64'd0);

    // R10 out-of-range and unused kind
    wr(2'd2, 5'd30, 64'hdead);
    wr(2'd3, 5'd0, 64'hbeef);
    rd_chk("R10 oob read", 2'd2, 5'd30);
    rd_chk("R10 kind3 read", 2'd3, 5'd0);
    rd_chk("R10 ctrl untouched", 2'd0, 5'd0);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      evt = {$urandom, $urandom};
      iend = ($urandom % 5) == 0;
      we = ($urandom % 3) == 0;
      wk = 2'($urandom);
      wi = 5'($urandom % 32);
      case ($urandom % 3)
        0: wd = 64'($urandom % 64);
        1: wd = {$urandom, $urandom};
        default: wd = 64'hffff_ffff_ffff_fff0 | 64'($urandom % 16);
      endcase
      cyc();
      chk("R8 mod random", {35'd0, mod}, {35'd0, m_mod});
      rd_chk("R2 random read", 2'($urandom), 5'($urandom % 32));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule